// File: doc/BRIEF.md
# Asynchronous Parallel Memory Access Controller

This block runs on a single controller clock and drives an asynchronous parallel memory bus. The bus has one active-low select line per memory region, separate read and write strobes, an address and a data path with an output enable. The data path is split into in, out and enable pins. The bus can serve NAND flash or SRAM-like parts. A host issues one read or write at a time through a valid/ready request port. Each request carries a region index, an address and write data. The host receives the captured read data together with a one-cycle completion pulse.

Each access runs three programmed phases in order: setup, strobe and hold. The read and write directions have their own lengths for each phase. Between accesses the controller enforces three idle windows:

- a short turnaround window after any access;
- a minimum gap that applies when a write follows a read;
- a minimum gap that applies when a read follows a write.

The two direction gaps can be far longer than the turnaround field allows, so slow flash parts can meet their direction-change timing without dummy accesses.

When the bus is idle, the controller drives the data pins with the last word it wrote. A mode bit chooses when this drive resumes after a read. It can resume right at the end of the read hold phase, or only after a further turnaround window. The second choice lets a slow device release the bus first.

Top module: `amc_ctrl`

## Requirements
- R1: A read shows rd_setup+1 cycles with its select low and both strobes high, then rd_strobe+1 cycles with mem_oe_n low, then rd_hold+1 cycles with select low and strobes high, with no gaps between the phases.
- R2: A write runs the same three-phase pattern using wr_setup+1, wr_strobe+1 and wr_hold+1 cycles, with mem_we_n low only in the strobe phase. mem_dq_oe is high and mem_dq_out equals the request data throughout the access.
- R3: During an access, only mem_cs_n[i] is low, where i is the region index of the request. mem_addr equals the request address. No select and no strobe is low outside an access, and mem_oe_n and mem_we_n are never low together.
- R4: rsp_rdata holds the mem_dq_in value sampled on the last clock of the read strobe phase. rsp_done is high for exactly one cycle: the first cycle after the last hold cycle.
- R5: Between the last hold cycle of one access and the first setup cycle of the next, there are at least cfg_ta+1 idle cycles. When the next request is already waiting, the idle count is exactly 1+max(cfg_ta, G). G is the direction gap from R6 or R7, or 0 when the direction does not change.
- R6: A write that follows a read uses G = cfg_rw_gap (0 to 31 cycles).
- R7: A read that follows a write uses G = cfg_wr_gap (0 to 31 cycles).
- R8: req_ready is low during an access and while any applicable gap is running. A waiting request is accepted on the first cycle its gaps allow.
- R9: mem_dq_oe is low from the first setup cycle through the last hold cycle of every read.
- R10: With cfg_park_late=0, mem_dq_oe is high in the first idle cycle after a read.
- R11: With cfg_park_late=1, mem_dq_oe stays low for exactly cfg_ta idle cycles after a read, then goes high.
- R12: When mem_dq_oe is high outside an access, mem_dq_out is the data of the most recent write, or 0 if no write has happened since reset.
- R13: After reset, all selects and strobes are high, mem_dq_oe is 1, mem_dq_out is 0, rsp_done is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_setup | input | PH_W | Read setup length minus one |
| cfg_rd_strobe | input | PH_W | Read strobe length minus one |
| cfg_rd_hold | input | PH_W | Read hold length minus one |
| cfg_wr_setup | input | PH_W | Write setup length minus one |
| cfg_wr_strobe | input | PH_W | Write strobe length minus one |
| cfg_wr_hold | input | PH_W | Write hold length minus one |
| cfg_ta | input | TA_W | Turnaround idle cycles after any access |
| cfg_rw_gap | input | GAP_W | Minimum extra idle cycles, read then write |
| cfg_wr_gap | input | GAP_W | Minimum extra idle cycles, write then read |
| cfg_park_late | input | 1 | 1: wait the turnaround window after a read before driving the bus |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | CS_W | Region index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| mem_cs_n | output | NCS | Active-low region selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data to drive on the bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DW | Data sampled from the bus |

## Verification
The bench builds the controller with PH_W=2. This keeps each phase within 1 to 4 cycles, so it can sweep all 64 read setup/strobe/hold combinations, each paired with a rotated write combination. It uses TA_W=2 and GAP_W=5. Every turnaround value and both parking modes are then reachable, and the gap values include 20 cycles, the length a 100 ns direction gap needs at a 5 ns clock. Every gap is checked against 1+max(turnaround, gap) idle cycles. The read data input changes every cycle, so the capture check pins the sample to the last strobe clock.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/amc_gap_ctr.sv
module amc_gap_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_write,
  input  logic [PH_W-1:0] rd_setup,
  input  logic [PH_W-1:0] rd_strobe,
  input  logic [PH_W-1:0] rd_hold,
  input  logic [PH_W-1:0] wr_setup,
  input  logic [PH_W-1:0] wr_strobe,
  input  logic [PH_W-1:0] wr_hold,
  output phase_e          phase,
  output logic            dir_wr,
  output logic            last_strobe,
  output logic            last_hold
);
  phase_e          phase_q, phase_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            dir_q, dir_d;
  logic            cnt_zero, seq_en;

  assign cnt_zero = (cnt_q == '0);
  assign seq_en   = start || (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_SETUP;
        dir_d   = start_write;
        cnt_d   = start_write ? wr_setup : rd_setup;
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d = PH_STROBE;
        cnt_d   = dir_q ? wr_strobe : rd_strobe;
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (cnt_zero) begin
        phase_d = PH_HOLD;
        cnt_d   = dir_q ? wr_hold : rd_hold;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_zero) phase_d = PH_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

  assign phase       = phase_q;
  assign dir_wr      = dir_q;
  assign last_strobe = (phase_q == PH_STROBE) && cnt_zero;
  assign last_hold   = (phase_q == PH_HOLD) && cnt_zero;

  // Phases only advance in order setup -> strobe -> hold -> idle
  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> (phase_q == PH_IDLE || phase_q == PH_SETUP));
  assert_strobe_after_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_SETUP || phase_q == PH_STROBE));
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int PH_W  = 4,
  parameter int TA_W  = 2,
  parameter int GAP_W = 5,
  localparam int CS_W = $clog2(NCS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  cfg_rd_setup,
  input  logic [PH_W-1:0]  cfg_rd_strobe,
  input  logic [PH_W-1:0]  cfg_rd_hold,
  input  logic [PH_W-1:0]  cfg_wr_setup,
  input  logic [PH_W-1:0]  cfg_wr_strobe,
  input  logic [PH_W-1:0]  cfg_wr_hold,
  input  logic [TA_W-1:0]  cfg_ta,
  input  logic [GAP_W-1:0] cfg_rw_gap,
  input  logic [GAP_W-1:0] cfg_wr_gap,
  input  logic             cfg_park_late,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CS_W-1:0]  req_cs,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NCS-1:0]   mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  phase_e phase;
  logic   dir_wr, last_strobe, last_hold, busy, accept;
  logic   ta_zero, rw_zero, wr_zero;
  logic   rd_end, wr_end, park_wait;

  logic [CS_W-1:0] sel_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   park_q, rdata_q;
  logic            last_rd_q, done_q;

  assign busy   = (phase != PH_IDLE);
  assign rd_end = last_hold && !dir_wr;
  assign wr_end = last_hold && dir_wr;

  // A request starts only when idle and every window that applies is spent
  assign req_ready = !busy && ta_zero && (req_write ? rw_zero : wr_zero);
  assign accept    = req_valid && req_ready;

  amc_seq #(.PH_W(PH_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .rd_setup    (cfg_rd_setup),
    .rd_strobe   (cfg_rd_strobe),
    .rd_hold     (cfg_rd_hold),
    .wr_setup    (cfg_wr_setup),
    .wr_strobe   (cfg_wr_strobe),
    .wr_hold     (cfg_wr_hold),
    .phase       (phase),
    .dir_wr      (dir_wr),
    .last_strobe (last_strobe),
    .last_hold   (last_hold)
  );

  amc_gap_ctr #(.W(TA_W)) ta_ctr_i (
    .clk(clk), .rst_n(rst_n), .load(last_hold), .load_val(cfg_ta), .zero(ta_zero));
  amc_gap_ctr #(.W(GAP_W)) rw_ctr_i (
    .clk(clk), .rst_n(rst_n), .load(rd_end), .load_val(cfg_rw_gap), .zero(rw_zero));
  amc_gap_ctr #(.W(GAP_W)) wr_ctr_i (
    .clk(clk), .rst_n(rst_n), .load(wr_end), .load_val(cfg_wr_gap), .zero(wr_zero));

  // Request fields, latched on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      sel_q  <= req_cs;
      addr_q <= req_addr;
    end
  end

  // Written word doubles as the idle park value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      park_q <= '0;
    else if (accept && req_write)    park_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rdata_q <= '0;
    else if (last_strobe && !dir_wr)  rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      done_q <= last_hold;
      if (last_hold) last_rd_q <= !dir_wr;
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = !(busy && (sel_q == CS_W'(i)));
  end

  assign mem_oe_n   = !((phase == PH_STROBE) && !dir_wr);
  assign mem_we_n   = !((phase == PH_STROBE) && dir_wr);
  assign mem_addr   = addr_q;
  assign park_wait  = cfg_park_late && last_rd_q && !ta_zero;
  assign mem_dq_oe  = busy ? dir_wr : !park_wait;
  assign mem_dq_out = park_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_strobe_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));
  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n) |-> !mem_dq_oe);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !(&mem_cs_n));
  assert_rw_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |-> rw_zero);
  assert_wr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |-> wr_zero);
  assert_park_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(mem_dq_out));
endmodule

// File: tb/amc_ctrl_tb_top.sv
`timescale 1ns/1ps
module amc_ctrl_tb_top;
  localparam int NCS = 4, AW = 12, DW = 16, PH_W = 2, TA_W = 2, GAP_W = 5;
  localparam int CS_W = 2;

  logic clk, rst_n;
  logic [PH_W-1:0] rs, rt, rh, ws, wt, wh;
  logic [TA_W-1:0] ta;
  logic [GAP_W-1:0] rwg, wrg;
  logic park_late;
  logic req_valid, req_write, req_ready, rsp_done, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [CS_W-1:0] req_cs;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic [NCS-1:0] mem_cs_n;

  int cyc = 0;
  int checks = 0, failures = 0;
  int prev_end = 0;
  bit prev_wr = 0, have_prev = 0, finished = 0;
  logic [DW-1:0] park_exp = '0;
  int wcount = 0;

  amc_ctrl #(.NCS(NCS), .AW(AW), .DW(DW), .PH_W(PH_W), .TA_W(TA_W), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(rs), .cfg_rd_strobe(rt), .cfg_rd_hold(rh),
    .cfg_wr_setup(ws), .cfg_wr_strobe(wt), .cfg_wr_hold(wh),
    .cfg_ta(ta), .cfg_rw_gap(rwg), .cfg_wr_gap(wrg), .cfg_park_late(park_late),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] bus_pat(input int c);
    bus_pat = DW'((c * 40503) ^ 23130);
  endfunction
  assign mem_dq_in = bus_pat(cyc);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic access(input bit wr, input int cs, input int a);
    int su = 0, st = 0, ho = 0, first = -1, last = -1, off = 0, n = 0, g;
    logic [DW-1:0] d, rexp;
    int exp_su, exp_st, exp_ho;
    bit ok_cs = 1, ok_oe = 1, ok_rdy = 1, ok_str = 1;
    d = DW'(wcount * 4999 + 17);
    if (wr) wcount++;
    rexp = '0;
    req_valid = 1'b1; req_write = wr; req_cs = CS_W'(cs);
    req_addr = AW'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (rsp_done || n > 200) break;
      if (!(&mem_cs_n)) begin
        if (first < 0) first = cyc;
        last = cyc;
        if (mem_cs_n != ~(NCS'(1) << cs) || mem_addr != AW'(a)) ok_cs = 0;
        if (mem_dq_oe != wr || (wr && mem_dq_out != d)) ok_oe = 0;
        if (req_ready) ok_rdy = 0;
        if ((wr ? mem_we_n : mem_oe_n) == 1'b0) begin
          st++;
          if (!(wr ? mem_oe_n : mem_we_n)) ok_str = 0;
          if (!wr) rexp = bus_pat(cyc);
        end else begin
          if (!mem_oe_n || !mem_we_n) ok_str = 0;
          if (st == 0) su++; else ho++;
        end
      end else if (first >= 0) ok_str = 0;
    end
    exp_su = wr ? int'(ws) + 1 : int'(rs) + 1;
    exp_st = wr ? int'(wt) + 1 : int'(rt) + 1;
    exp_ho = wr ? int'(wh) + 1 : int'(rh) + 1;
    if (wr) begin
      chk(su == exp_su, "R2 write setup", su, exp_su);
      chk(st == exp_st, "R2 write strobe", st, exp_st);
      chk(ho == exp_ho, "R2 write hold", ho, exp_ho);
      chk(ok_oe, "R2 write drive/data", int'(mem_dq_out), int'(d));
    end else begin
      chk(su == exp_su, "R1 read setup", su, exp_su);
      chk(st == exp_st, "R1 read strobe", st, exp_st);
      chk(ho == exp_ho, "R1 read hold", ho, exp_ho);
      chk(ok_oe, "R9 read releases bus", int'(mem_dq_oe), 0);
      chk(rsp_rdata == rexp, "R4 read capture", int'(rsp_rdata), int'(rexp));
    end
    chk(ok_cs, "R3 select/address", int'(mem_cs_n), int'(~(NCS'(1) << cs)));
    chk(ok_str, "R3 strobe placement", int'({mem_oe_n, mem_we_n}), 3);
    chk(ok_rdy, "R8 not ready while busy", 1, 0);
    chk(rsp_done && cyc == last + 1, "R4 done timing", cyc, last + 1);
    if (have_prev) begin
      g = int'(ta);
      if (!prev_wr && wr && int'(rwg) > g) g = int'(rwg);
      if (prev_wr && !wr && int'(wrg) > g) g = int'(wrg);
      if (!prev_wr && wr)
        chk(first - prev_end - 1 == g + 1, "R6 read-to-write gap", first - prev_end - 1, g + 1);
      else if (prev_wr && !wr)
        chk(first - prev_end - 1 == g + 1, "R7 write-to-read gap", first - prev_end - 1, g + 1);
      else
        chk(first - prev_end - 1 == g + 1, "R5 turnaround gap", first - prev_end - 1, g + 1);
    end
    if (wr) park_exp = d;
    if (!wr) begin
      while (!mem_dq_oe && off < 50) begin off++; @(negedge clk); end
      if (park_late) chk(off == int'(ta), "R11 late park delay", off, int'(ta));
      else           chk(off == 0, "R10 early park", off, 0);
    end
    chk(mem_dq_oe && mem_dq_out == park_exp, "R12 parked value", int'(mem_dq_out), int'(park_exp));
    prev_end = last; prev_wr = wr; have_prev = 1;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    have_prev = 0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cs = '0;
    req_addr = '0; req_wdata = '0;
    rs = '0; rt = '0; rh = '0; ws = '0; wt = '0; wh = '0;
    ta = '0; rwg = '0; wrg = '0; park_late = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(mem_cs_n == '1 && mem_oe_n && mem_we_n, "R13 bus idle", int'(mem_cs_n), NCS'('1));
    chk(mem_dq_oe && mem_dq_out == '0, "R13 park zero", int'(mem_dq_out), 0);
    chk(!rsp_done && req_ready, "R13 done/ready", int'({rsp_done, req_ready}), 1);
    // R12: a read before any write parks zero
    access(1'b0, 1, 12'h011);
    settle();

    // Exhaustive phase sweep, turnaround and gaps zero
    for (int k = 0; k < 64; k++) begin
      rs = PH_W'(k); rt = PH_W'(k >> 2); rh = PH_W'(k >> 4);
      ws = rh; wt = rs; wh = rt;
      access(1'b1, k % NCS, k * 3);
      access(1'b0, (k + 1) % NCS, k * 5 + 1);
      access(1'b0, (k + 2) % NCS, k * 7 + 2);
      access(1'b1, (k + 3) % NCS, k * 11 + 3);
      settle();
    end

    // Turnaround, direction gaps and park mode sweep
    rs = 2'd1; rt = 2'd2; rh = 2'd1; ws = 2'd0; wt = 2'd1; wh = 2'd2;
    for (int t = 0; t < 4; t++)
      for (int pk = 0; pk < 2; pk++)
        for (int gi = 0; gi < 3; gi++)
          for (int gj = 0; gj < 3; gj++) begin
            ta = TA_W'(t); park_late = pk[0];
            rwg = (gi == 0) ? 5'd0 : (gi == 1) ? 5'd7 : 5'd20;
            wrg = (gj == 0) ? 5'd0 : (gj == 1) ? 5'd4 : 5'd17;
            access(1'b1, 0, 100 + t);
            access(1'b0, 1, 200 + gi);
            access(1'b1, 2, 300 + gj);
            access(1'b1, 3, 400);
            access(1'b0, 0, 500);
            access(1'b0, 2, 600);
            settle();
          end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule